// File: doc/BRIEF.md
# Serial Audio Link Frame Receiver

This block sits on the controller side of a serial audio link and receives the codec's incoming data line. It runs on the link bit clock and the local frame sync. It rebuilds the frame from these: a 16-bit tag slot followed by twelve 20-bit slots, sent MSB first, 256 bit times in all. Each bit is sampled on the falling edge of the bit clock, half a period after the transmitter launched it.

The tag tells the receiver which slots carry real data in the current frame. Only tagged slots are captured. At the end of the frame, the captured slots are copied into output holding registers as a group. The block then raises one frame-done pulse, and a valid strobe for each slot that was updated. The outputs are:

- from slot 1: the status register address echo and the slot-request flags
- from slot 2: the register read data
- from slots 3 and 4: the left and right record samples
- from slot 5: the modem line sample
- from slots 6 to 11: six alternative record samples
- from slot 12: the GPIO status word

Top module: `slotrx_top`

## Requirements
- R1: All receiver state changes on the falling edge of `bitClk`. `syncIn` and `serIn` are expected to change on rising edges.
- R2: Bit 0 of a frame is the first falling-edge sample where `syncIn` is 1 after a sample where it was 0. Bits 0..15 form the tag and bits 16..255 form slots 1..12 of 20 bits each. Every field arrives MSB first.
- R3: Tag bit (15 − n) marks slot n (n = 1..12) as valid. Tag bit 15 does not gate any slot.
- R4: A slot's output and valid strobe are updated only when its tag bit in the same frame is 1. Otherwise the output keeps its previous value and its strobe stays low, whatever data the slot carried.
- R5: From slot 1, `statusAddr` takes slot bits 18:12 and `slotReq` takes slot bits 11:2.
- R6: `statusData` (slot 2) and `modemData` (slot 5) take bits 19:4 of their slot. Bits 3:0 are ignored.
- R7: `pcmLeft` (slot 3), `pcmRight` (slot 4), `altPcm[k]` (slot 6+k) and `gpioStatus` (slot 12) take the full 20-bit slot.
- R8: At the falling edge that samples frame bit 255, all outputs update together and `frameDone` goes high for exactly one cycle. Each valid strobe is high only in that cycle.
- R9: A rising edge of `syncIn` at any point restarts the frame at bit 0. An interrupted frame produces no `frameDone` and changes no output.
- R10: While `rstN` is low, all outputs are 0. After reset, no output changes until a `syncIn` rising edge has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Link bit clock; the receiver samples on its falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| syncIn | input | 1 | Local frame sync, high for the first 16 bits of a frame |
| serIn | input | 1 | Incoming serial data line |
| frameDone | output | 1 | One-cycle pulse when a complete frame has been received |
| statusAddr | output | 7 | Echoed status register address (slot 1) |
| slotReq | output | 10 | Slot-request flags (slot 1) |
| statusAddrValid | output | 1 | Slot 1 updated this frame |
| statusData | output | 16 | Register read data (slot 2) |
| statusDataValid | output | 1 | Slot 2 updated this frame |
| pcmLeft | output | 20 | Left record sample (slot 3) |
| pcmLeftValid | output | 1 | Slot 3 updated this frame |
| pcmRight | output | 20 | Right record sample (slot 4) |
| pcmRightValid | output | 1 | Slot 4 updated this frame |
| modemData | output | 16 | Modem line sample (slot 5) |
| modemValid | output | 1 | Slot 5 updated this frame |
| altPcm | output | 6x20 | Alternative record samples, element k from slot 6+k |
| altPcmValid | output | 6 | Per-element update strobes for altPcm |
| gpioStatus | output | 20 | GPIO read and interrupt status (slot 12) |
| gpioValid | output | 1 | Slot 12 updated this frame |

## Verification
The bench runs the receiver through several kinds of input:

- Frames with every slot tagged show that each field is placed at the right bit position. These frames put nonzero data in the discarded low nibbles.
- Frames with sparse tags, including one where tag bit 15 is clear, and a frame with an empty tag tell gating by slot from gating by the frame flag. They also show that untagged outputs hold their old values.
- A frame cut short by an early sync rise, and serial noise sent before the first sync, check that alignment comes only from sync edges.
- The reset phase confirms the all-zero starting state.

// File: rtl/slotrx_pkg.sv
package slotrx_pkg;
  parameter int TAG_BITS   = 16;
  parameter int SLOT_BITS  = 20;
  parameter int SLOT_COUNT = 12;
  localparam int IDX_W     = 4;

  typedef struct packed {
    logic             shiftEn;
    logic             frameStart;
    logic             tagDone;
    logic             slotDone;
    logic             frameDone;
    logic [IDX_W-1:0] slotIdx;
  } rxStrb_t;
endpackage

// File: rtl/slotrx_ctrl.sv
module slotrx_ctrl
  import slotrx_pkg::*;
#(
  parameter int TAG_W     = TAG_BITS,
  parameter int SLOT_W    = SLOT_BITS,
  parameter int NUM_SLOTS = SLOT_COUNT
) (
  input  logic    bitClk,
  input  logic    rstN,
  input  logic    syncIn,
  output rxStrb_t strb
);
  localparam int BIT_W = $clog2(SLOT_W);
  localparam logic [BIT_W-1:0] TAG_LAST  = BIT_W'(TAG_W - 1);
  localparam logic [BIT_W-1:0] SLOT_LAST = BIT_W'(SLOT_W - 1);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(NUM_SLOTS);

  logic             syncPrev;
  logic             locked;
  logic [IDX_W-1:0] slotNum;
  logic [BIT_W-1:0] bitCnt;

  logic             syncRise;
  logic             active;
  logic [IDX_W-1:0] curSlot;
  logic [BIT_W-1:0] curBit;
  logic             lastBit;

  always_comb begin
    syncRise = syncIn && !syncPrev;
    active   = syncRise || locked;
    curSlot  = syncRise ? '0 : slotNum;
    curBit   = syncRise ? '0 : bitCnt;
    lastBit  = (curSlot == '0) ? (curBit == TAG_LAST) : (curBit == SLOT_LAST);

    strb            = '0;
    strb.shiftEn    = active;
    strb.frameStart = syncRise;
    strb.tagDone    = active && (curSlot == '0) && lastBit;
    strb.slotDone   = active && (curSlot != '0) && lastBit;
    strb.frameDone  = active && (curSlot == LAST_SLOT) && lastBit;
    strb.slotIdx    = curSlot;
  end

  always_ff @(negedge bitClk or negedge rstN) begin
    if (!rstN) begin
      syncPrev <= 1'b0;
      locked   <= 1'b0;
      slotNum  <= '0;
      bitCnt   <= '0;
    end else begin
      syncPrev <= syncIn;
      if (active) begin
        if (lastBit) begin
          bitCnt <= '0;
          if (curSlot == LAST_SLOT) begin
            locked  <= 1'b0;
            slotNum <= '0;
          end else begin
            locked  <= 1'b1;
            slotNum <= curSlot + 1'b1;
          end
        end else begin
          locked  <= 1'b1;
          slotNum <= curSlot;
          bitCnt  <= curBit + 1'b1;
        end
      end
    end
  end

  AST_RESYNC_ALIGN: assert property (@(negedge bitClk) disable iff (!rstN)
    (syncIn && !syncPrev) |=> (locked && slotNum == '0 && bitCnt == BIT_W'(1))); // R9

  AST_FRAME_ENDS_IDLE: assert property (@(negedge bitClk) disable iff (!rstN)
    strb.frameDone |=> (!locked && slotNum == '0)); // R8
endmodule

// File: rtl/slotrx_datapath.sv
module slotrx_datapath
  import slotrx_pkg::*;
#(
  parameter int TAG_W     = TAG_BITS,
  parameter int SLOT_W    = SLOT_BITS,
  parameter int NUM_SLOTS = SLOT_COUNT
) (
  input  logic                                bitClk,
  input  logic                                rstN,
  input  logic                                serIn,
  input  rxStrb_t                             strb,
  output logic [NUM_SLOTS-1:0][SLOT_W-1:0]    holdWord,
  output logic [NUM_SLOTS-1:0]                holdVld,
  output logic                                frameDone
);
  logic [SLOT_W-2:0]               shReg;
  logic [SLOT_W-1:0]               word;
  logic [TAG_W-1:0]                tagReg;
  logic [NUM_SLOTS-1:0][SLOT_W-1:0] stage;
  logic [NUM_SLOTS-1:0]            stageVld;
  logic [NUM_SLOTS-1:0]            capNow;

  assign word = {shReg, serIn};

  always_ff @(negedge bitClk or negedge rstN) begin
    if (!rstN) begin
      shReg     <= '0;
      tagReg    <= '0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= strb.frameDone;
      if (strb.shiftEn) shReg <= word[SLOT_W-2:0];
      if (strb.tagDone) tagReg <= word[TAG_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g + 1);
    localparam int               TAG_POS = TAG_W - 2 - g;

    assign capNow[g] = strb.slotDone && (strb.slotIdx == MY_IDX) && tagReg[TAG_POS];

    always_ff @(negedge bitClk or negedge rstN) begin
      if (!rstN) begin
        stage[g]    <= '0;
        stageVld[g] <= 1'b0;
        holdWord[g] <= '0;
        holdVld[g]  <= 1'b0;
      end else begin
        if (capNow[g]) stage[g] <= word;
        if (strb.frameStart || strb.frameDone) stageVld[g] <= 1'b0;
        else if (capNow[g])                    stageVld[g] <= 1'b1;
        holdVld[g] <= 1'b0;
        if (strb.frameDone) begin
          if (capNow[g]) begin
            holdWord[g] <= word;
            holdVld[g]  <= 1'b1;
          end else if (stageVld[g]) begin
            holdWord[g] <= stage[g];
            holdVld[g]  <= 1'b1;
          end
        end
      end
    end

    AST_VALID_NEEDS_TAG: assert property (@(negedge bitClk) disable iff (!rstN)
      holdVld[g] |-> tagReg[TAG_POS]); // R4
  end

  AST_HOLD_STABLE: assert property (@(negedge bitClk) disable iff (!rstN)
    !strb.frameDone |=> $stable(holdWord)); // R4
endmodule

// File: rtl/slotrx_top.sv
module slotrx_top
  import slotrx_pkg::*;
#(
  parameter int TAG_W     = TAG_BITS,
  parameter int SLOT_W    = SLOT_BITS,
  parameter int NUM_SLOTS = SLOT_COUNT,
  parameter int ADDR_W    = 7,
  parameter int REQ_W     = 10,
  parameter int FIELD_W   = 16,
  parameter int ALT_N     = 6
) (
  input  logic                        bitClk,
  input  logic                        rstN,
  input  logic                        syncIn,
  input  logic                        serIn,
  output logic                        frameDone,
  output logic [ADDR_W-1:0]           statusAddr,
  output logic [REQ_W-1:0]            slotReq,
  output logic                        statusAddrValid,
  output logic [FIELD_W-1:0]          statusData,
  output logic                        statusDataValid,
  output logic [SLOT_W-1:0]           pcmLeft,
  output logic                        pcmLeftValid,
  output logic [SLOT_W-1:0]           pcmRight,
  output logic                        pcmRightValid,
  output logic [FIELD_W-1:0]          modemData,
  output logic                        modemValid,
  output logic [ALT_N-1:0][SLOT_W-1:0] altPcm,
  output logic [ALT_N-1:0]            altPcmValid,
  output logic [SLOT_W-1:0]           gpioStatus,
  output logic                        gpioValid
);
  localparam int S_ADDR = 0;
  localparam int S_DATA = 1;
  localparam int S_LEFT = 2;
  localparam int S_RIGHT = 3;
  localparam int S_MODEM = 4;
  localparam int S_ALT0 = 5;
  localparam int S_GPIO = NUM_SLOTS - 1;
  localparam int LOW_W = SLOT_W - FIELD_W;

  rxStrb_t                         strb;
  logic [NUM_SLOTS-1:0][SLOT_W-1:0] holdWord;
  logic [NUM_SLOTS-1:0]            holdVld;

  slotrx_ctrl #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)) u_ctrl (
    .bitClk (bitClk),
    .rstN   (rstN),
    .syncIn (syncIn),
    .strb   (strb)
  );

  slotrx_datapath #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)) u_dp (
    .bitClk    (bitClk),
    .rstN      (rstN),
    .serIn     (serIn),
    .strb      (strb),
    .holdWord  (holdWord),
    .holdVld   (holdVld),
    .frameDone (frameDone)
  );

  assign statusAddr      = holdWord[S_ADDR][SLOT_W-2 -: ADDR_W];
  assign slotReq         = holdWord[S_ADDR][REQ_W+1:2];
  assign statusAddrValid = holdVld[S_ADDR];
  assign statusData      = holdWord[S_DATA][SLOT_W-1 -: FIELD_W];
  assign statusDataValid = holdVld[S_DATA];
  assign pcmLeft         = holdWord[S_LEFT];
  assign pcmLeftValid    = holdVld[S_LEFT];
  assign pcmRight        = holdWord[S_RIGHT];
  assign pcmRightValid   = holdVld[S_RIGHT];
  assign modemData       = holdWord[S_MODEM][SLOT_W-1 -: FIELD_W];
  assign modemValid      = holdVld[S_MODEM];
  assign gpioStatus      = holdWord[S_GPIO];
  assign gpioValid       = holdVld[S_GPIO];

  for (genvar k = 0; k < ALT_N; k++) begin : g_alt
    assign altPcm[k]      = holdWord[S_ALT0 + k];
    assign altPcmValid[k] = holdVld[S_ALT0 + k];
  end

  logic unusedBits;
  assign unusedBits = ^{holdWord[S_ADDR][SLOT_W-1], holdWord[S_ADDR][1:0],
                        holdWord[S_DATA][LOW_W-1:0], holdWord[S_MODEM][LOW_W-1:0]};

  AST_STROBE_WITH_DONE: assert property (@(negedge bitClk) disable iff (!rstN)
    (|holdVld) |-> frameDone); // R8

  AST_DONE_ONE_CYCLE: assert property (@(negedge bitClk) disable iff (!rstN)
    frameDone |=> !frameDone); // R8
endmodule

// File: tb/slotrx_top_bench.sv
module slotrx_top_bench;
  localparam int CLK_PERIOD = 10;

  logic bitClk = 1'b0;
  logic rstN = 1'b0;
  logic syncIn = 1'b0;
  logic serIn = 1'b0;

  logic             frameDone;
  logic [6:0]       statusAddr;
  logic [9:0]       slotReq;
  logic             statusAddrValid;
  logic [15:0]      statusData;
  logic             statusDataValid;
  logic [19:0]      pcmLeft, pcmRight, gpioStatus;
  logic             pcmLeftValid, pcmRightValid, gpioValid;
  logic [15:0]      modemData;
  logic             modemValid;
  logic [5:0][19:0] altPcm;
  logic [5:0]       altPcmValid;

  slotrx_top u_slotrx_top (
    .bitClk(bitClk), .rstN(rstN), .syncIn(syncIn), .serIn(serIn),
    .frameDone(frameDone), .statusAddr(statusAddr), .slotReq(slotReq),
    .statusAddrValid(statusAddrValid), .statusData(statusData),
    .statusDataValid(statusDataValid), .pcmLeft(pcmLeft), .pcmLeftValid(pcmLeftValid),
    .pcmRight(pcmRight), .pcmRightValid(pcmRightValid), .modemData(modemData),
    .modemValid(modemValid), .altPcm(altPcm), .altPcmValid(altPcmValid),
    .gpioStatus(gpioStatus), .gpioValid(gpioValid)
  );

  always #(CLK_PERIOD/2) bitClk = ~bitClk;

  int nChecks = 0;
  int nFails = 0;
  string phase = "reset";

  // Reference model: expected output state, updated behaviourally per frame
  logic [19:0] expHold [1:12];
  logic [12:1] expVld;
  logic        expDone;
  logic [19:0] curVals [1:12];
  logic [15:0] curTag;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s (%s): actual %h expected %h", req, what, phase, act, exp);
    end
  endtask

  task automatic checkAll();
    string rv;
    string rf;
    rv = (rstN == 1'b0) ? "R10" : "R4";
    rf = (rstN == 1'b0) ? "R10" : "R8";
    chk(rf, "frameDone", 32'(frameDone), 32'(expDone));
    chk((rstN == 1'b0) ? "R10" : "R5", "statusAddr", 32'(statusAddr), 32'(expHold[1][18:12]));
    chk((rstN == 1'b0) ? "R10" : "R5", "slotReq", 32'(slotReq), 32'(expHold[1][11:2]));
    chk((rstN == 1'b0) ? "R10" : "R6", "statusData", 32'(statusData), 32'(expHold[2][19:4]));
    chk((rstN == 1'b0) ? "R10" : "R7", "pcmLeft", 32'(pcmLeft), 32'(expHold[3]));
    chk((rstN == 1'b0) ? "R10" : "R7", "pcmRight", 32'(pcmRight), 32'(expHold[4]));
    chk((rstN == 1'b0) ? "R10" : "R6", "modemData", 32'(modemData), 32'(expHold[5][19:4]));
    for (int k = 0; k < 6; k++)
      chk((rstN == 1'b0) ? "R10" : "R7", "altPcm", 32'(altPcm[k]), 32'(expHold[6+k]));
    chk((rstN == 1'b0) ? "R10" : "R7", "gpioStatus", 32'(gpioStatus), 32'(expHold[12]));
    chk(rv, "valid strobes",
        32'({statusAddrValid, statusDataValid, pcmLeftValid, pcmRightValid, modemValid, altPcmValid, gpioValid}),
        32'({expVld[1], expVld[2], expVld[3], expVld[4], expVld[5], expVld[11], expVld[10],
             expVld[9], expVld[8], expVld[7], expVld[6], expVld[12]}));
  endtask

  // One bit time: check at the rising edge (outputs settled since the falling edge), then drive
  task automatic sendBit(input logic s, input logic d, input logic lastOfFrame);
    @(posedge bitClk);
    checkAll();
    expDone = 1'b0;
    expVld = '0;
    syncIn = s;
    serIn = d;
    if (lastOfFrame) begin
      // R8: everything lands at the falling edge that samples bit 255
      for (int n = 1; n <= 12; n++) begin
        if (curTag[15-n]) begin   // R3: tag bit (15-n) marks slot n
          expHold[n] = curVals[n];
          expVld[n] = 1'b1;
        end
      end
      expDone = 1'b1;
    end
  endtask

  function automatic logic [19:0] mkVal(input int f, input int s);
    int v;
    v = (f * 40503 + s * 7919 + 12345) ^ (s << 13) ^ (f << 7);
    return v[19:0];
  endfunction

  // R2: 16-bit tag then twelve 20-bit slots, MSB first, sync high for the tag
  task automatic sendFrame(input logic [15:0] tag, input int seed, input int len);
    curTag = tag;
    for (int n = 1; n <= 12; n++) curVals[n] = mkVal(seed, n);
    for (int i = 0; i < len; i++) begin
      logic d;
      if (i < 16) d = tag[15-i];
      else d = curVals[(i-16)/20 + 1][19 - ((i-16)%20)];
      sendBit(i < 16, d, (i == 255) && (len == 256));
    end
  endtask

  initial begin
    for (int n = 1; n <= 12; n++) expHold[n] = '0;
    expVld = '0;
    expDone = 1'b0;
    repeat (2) @(posedge bitClk);
    // R10: reset state
    for (int i = 0; i < 4; i++) sendBit(1'b0, 1'b1, 1'b0);
    rstN = 1'b1;
    // R10/R2: serial noise with sync low before the first sync edge changes nothing
    phase = "R10 pre-sync noise";
    for (int i = 0; i < 40; i++) sendBit(1'b0, 1'(i % 3 == 0), 1'b0);
    // R1 R5 R6 R7: all slots tagged, low nibbles nonzero
    phase = "R7 full tag";
    sendFrame(16'hFFF8, 1, 256);
    sendFrame(16'hFFF8, 2, 256);
    // R4 R3: sparse tag, untagged slots carry data but must hold
    phase = "R4 sparse tag";
    sendFrame(16'hD000, 3, 256);
    // R3: frame flag clear does not block slot 1 and slot 12
    phase = "R3 no frame flag";
    sendFrame(16'h4008, 4, 256);
    // R4: empty tag, frame done only
    phase = "R4 empty tag";
    sendFrame(16'h8000, 5, 256);
    // R9: interrupted frame, then resync
    phase = "R9 resync";
    sendFrame(16'hFFF8, 6, 100);
    sendFrame(16'hA9A8, 7, 256);
    sendFrame(16'hFFF8, 8, 37);
    for (int i = 0; i < 5; i++) sendBit(1'b0, 1'b1, 1'b0);
    phase = "R9 after resync";
    sendFrame(16'hFFF8, 9, 256);
    for (int i = 0; i < 3; i++) sendBit(1'b0, 1'b0, 1'b0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge bitClk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule